// File: doc/BRIEF.md
# Audio DMA Channel Sequencer

This block runs one direction of an audio DMA channel. It takes 32-bit words from a codec-side receive FIFO and writes them into a memory buffer. Software sets a buffer start address and a byte length, then pulses an enable input. The channel pops one FIFO word at a time and issues it as a memory write on a request/acknowledge pair. The write address advances and a live remaining-byte counter counts down on each acknowledge.

A block that reaches zero ends by itself and raises a sticky transfer-end interrupt. When the reload level is set, the block instead rewinds to the address and length latched at enable and continues with no software action. A stop pulse ends the channel at any point and also raises the interrupt. The remaining counter then shows how many bytes never reached memory.

If a memory write is still outstanding at the stop, the channel holds a stop-pending flag until that write is acknowledged. While the flag is set, an enable pulse is refused.

Top module: `audio_dma_seq`

## Requirements
- R1: An enable pulse while idle, not stop-pending and with a non-zero length loads `remain` with `cfg_bytes` and `mem_addr` with `cfg_start`, and sets `busy` on the next cycle. A zero length leaves the channel idle.
- R2: Only a cycle with `mem_req` and `mem_ack` both high counts as a transfer. Each such cycle adds 4 to `mem_addr` and subtracts 4 from `remain`.
- R3: Once raised, `mem_req` stays high with `mem_addr` and `mem_wdata` unchanged until the cycle it is acknowledged. `mem_wdata` carries the FIFO word popped for it.
- R4: An acknowledge that takes `remain` from 4 to 0, with reload low, returns the channel to idle and sets `irq`.
- R5: A further enable pulse after completion, with the configuration inputs unchanged, restarts from the same start address with the full length.
- R6: With `cfg_reload` high, the final acknowledge of a block reloads the start address and length latched at enable. `busy` stays high and `irq` is set.
- R7: A stop pulse while busy clears `busy` on the next cycle and sets `irq`. `remain` then holds the bytes not transferred.
- R8: A stop that finds a write unacknowledged sets `stop_pending` and keeps the request open. No FIFO pop happens while `stop_pending` is set. The acknowledge of that write counts as a transfer (R2) and clears `stop_pending` and `mem_req`.
- R9: While `stop_pending` is 1, an enable pulse does not start the channel.
- R10: `irq` is sticky and is cleared by `irq_clear`. A set in the same cycle wins over the clear. A stop that coincides with the final acknowledge leaves a single interrupt, which one clear removes.
- R11: An enable pulse while busy, and a stop pulse while idle, change neither address, count nor state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | AW | Buffer start byte address |
| cfg_bytes | input | CW | Block length in bytes, multiple of 4 |
| cfg_enable | input | 1 | Start pulse |
| cfg_reload | input | 1 | Auto-reload level |
| cfg_stop | input | 1 | Forced stop pulse |
| irq_clear | input | 1 | Clears the transfer-end flag |
| fifo_valid | input | 1 | Codec FIFO holds a word |
| fifo_data | input | DW | Codec FIFO head word |
| fifo_pop | output | 1 | Takes the FIFO head word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |
| remain | output | CW | Bytes still to move |
| busy | output | 1 | Channel running |
| stop_pending | output | 1 | Forced stop waiting for an in-flight write |
| irq | output | 1 | Sticky transfer-end flag |

## Verification
The assertions assume that `mem_ack` rises only while `mem_req` is high. They also assume that `cfg_bytes` is a multiple of 4 and that enable and stop are single-cycle pulses. The stimulus keeps to these rules: acknowledges are generated only from the registered request, and lengths are drawn as multiples of 4 (zero included). Directed cases cover a stop with no write open, a stop with a write open, and a stop on the final acknowledge. They also cover an enable during the pending window and reload cycling. A long random run adds these pulses at random against a random acknowledge delay.

// File: rtl/audio_dma_seq.sv
module audio_dma_seq #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_start,
  input  logic [CW-1:0] cfg_bytes,
  input  logic          cfg_enable,
  input  logic          cfg_reload,
  input  logic          cfg_stop,
  input  logic          irq_clear,
  input  logic          fifo_valid,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_pop,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  output logic [CW-1:0] remain,
  output logic          busy,
  output logic          stop_pending,
  output logic          irq
);
  localparam int STEP = DW / 8;
  localparam logic [AW-1:0] ASTEP = AW'(STEP);
  localparam logic [CW-1:0] CSTEP = CW'(STEP);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;

  state_t        st;
  logic [AW-1:0] addr_q, base_q;
  logic [CW-1:0] rem_q, len_q;
  logic [DW-1:0] data_q;
  logic          req_q, irq_q;

  wire run      = (st == S_RUN);
  wire drain    = (st == S_DRAIN);
  wire xfer     = req_q && mem_ack;
  wire last     = xfer && (rem_q == CSTEP);
  wire start_ok = (st == S_IDLE) && cfg_enable && (cfg_bytes != '0);
  wire rewind   = last && cfg_reload && !cfg_stop;

  assign fifo_pop     = run && !req_q && fifo_valid && !cfg_stop;
  assign mem_req      = req_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = data_q;
  assign remain       = rem_q;
  assign busy         = run;
  assign stop_pending = drain;
  assign irq          = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      base_q <= '0;
      rem_q  <= '0;
      len_q  <= '0;
      data_q <= '0;
      req_q  <= 1'b0;
    end else if (start_ok) begin
      st     <= S_RUN;
      addr_q <= cfg_start;
      base_q <= cfg_start;
      rem_q  <= cfg_bytes;
      len_q  <= cfg_bytes;
    end else if (run) begin
      if (xfer) begin
        addr_q <= addr_q + ASTEP;
        rem_q  <= rem_q - CSTEP;
        req_q  <= 1'b0;
      end
      if (rewind) begin
        addr_q <= base_q;
        rem_q  <= len_q;
      end else if (last) begin
        st <= S_IDLE;
      end else if (cfg_stop) begin
        st <= (req_q && !mem_ack) ? S_DRAIN : S_IDLE;
      end
      if (fifo_pop) begin
        req_q  <= 1'b1;
        data_q <= fifo_data;
      end
    end else if (drain && xfer) begin
      addr_q <= addr_q + ASTEP;
      rem_q  <= rem_q - CSTEP;
      req_q  <= 1'b0;
      st     <= S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        irq_q <= 1'b0;
    else if (run && (last || cfg_stop)) irq_q <= 1'b1;
    else if (irq_clear)                irq_q <= 1'b0;
  end

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && (remain != CSTEP) |=> remain == $past(remain) - CSTEP);

  a_r4_natural_end: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_req && mem_ack && (remain == CSTEP) && !cfg_reload |=> !busy && irq);

  a_r7_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_stop |=> !busy && irq);

  a_r8_no_pop_pending: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pending |-> !fifo_pop && mem_req);

  a_r8_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pending && mem_ack |=> !stop_pending && !mem_req);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pending |=> !busy);

  a_r1_state_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, stop_pending}));
endmodule

// File: tb/audio_dma_seq_bench.sv
module audio_dma_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_start = '0;
  logic [15:0] cfg_bytes = '0;
  logic        cfg_enable = 1'b0, cfg_reload = 1'b0, cfg_stop = 1'b0, irq_clear = 1'b0;
  logic        fifo_valid = 1'b0;
  logic [31:0] fifo_data = '0;
  logic        fifo_pop, mem_req, mem_ack = 1'b0, busy, stop_pending, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [15:0] remain;

  audio_dma_seq u_audio_dma_seq (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_bytes(cfg_bytes),
    .cfg_enable(cfg_enable), .cfg_reload(cfg_reload), .cfg_stop(cfg_stop),
    .irq_clear(irq_clear), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .remain(remain), .busy(busy),
    .stop_pending(stop_pending), .irq(irq));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;

  // behavioural reference: 0 idle, 1 running, 2 stop pending
  int          m_mode = 0;
  logic [31:0] m_addr = '0, m_base = '0, m_data = '0;
  int          m_rem = 0, m_len = 0;
  bit          m_req = 0, m_irq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_addr = '0; m_base = '0; m_data = '0;
      m_rem = 0; m_len = 0; m_req = 0; m_irq = 0;
    end else begin
      bit took, fin, pop;
      took = m_req && mem_ack;
      fin  = took && (m_rem == 4);
      pop  = (m_mode == 1) && !m_req && fifo_valid && !cfg_stop;
      if (m_mode == 1 && (fin || cfg_stop)) m_irq = 1;
      else if (irq_clear) m_irq = 0;
      if (m_mode == 0) begin
        if (cfg_enable && cfg_bytes != 0) begin
          m_mode = 1; m_addr = cfg_start; m_base = cfg_start;
          m_rem = int'(cfg_bytes); m_len = int'(cfg_bytes);
        end
      end else if (m_mode == 1) begin
        bit was_open;
        was_open = m_req && !mem_ack;
        if (took) begin m_addr += 4; m_rem -= 4; m_req = 0; end
        if (fin && cfg_reload && !cfg_stop) begin m_addr = m_base; m_rem = m_len; end
        else if (fin) m_mode = 0;
        else if (cfg_stop) m_mode = was_open ? 2 : 0;
        if (pop) begin m_req = 1; m_data = fifo_data; end
      end else if (took) begin
        m_addr += 4; m_rem -= 4; m_req = 0; m_mode = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(remain == m_rem[15:0], "R2 remain", remain, m_rem);
    chk(mem_addr == m_addr, "R2 mem_addr", mem_addr, m_addr);
    chk(busy == (m_mode == 1), "R4 busy", busy, m_mode == 1);
    chk(stop_pending == (m_mode == 2), "R8 stop_pending", stop_pending, m_mode == 2);
    chk(mem_req == m_req, "R3 mem_req", mem_req, m_req);
    chk(irq == m_irq, "R10 irq", irq, m_irq);
    if (m_req) chk(mem_wdata == m_data, "R3 mem_wdata", mem_wdata, m_data);
  endtask

  // ack_mode: 0 random, 1 never, 2 always while requested
  int ack_mode = 0, fv_mode = 1;
  bit nxt_en = 0, nxt_stop = 0, nxt_clr = 0;

  task automatic step();
    @(negedge clk);
    cycles++;
    if (rst_n) compare();
    cfg_enable = nxt_en; cfg_stop = nxt_stop; irq_clear = nxt_clr;
    nxt_en = 0; nxt_stop = 0; nxt_clr = 0;
    fifo_valid = (fv_mode == 1) ? 1'b1 : (fv_mode == 0) ? 1'b0 : ($urandom % 3 != 0);
    fifo_data = $urandom;
    case (ack_mode)
      0: mem_ack = mem_req && ($urandom % 3 == 0);
      1: mem_ack = 1'b0;
      default: mem_ack = mem_req;
    endcase
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 150000) begin
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    finish_run();
  end

  initial begin
    steps(3);
    chk(!busy && !mem_req && remain == 0 && !irq && !stop_pending, "R1 reset state", busy, 0);
    rst_n = 1'b1;
    steps(2);

    // R1 zero length ignored
    cfg_start = 32'h1000; cfg_bytes = 0; nxt_en = 1; steps(3);
    chk(!busy, "R1 zero length start", busy, 0);

    // R1 R4 single block
    ack_mode = 2; cfg_bytes = 16; nxt_en = 1; steps(2);
    chk(busy && remain == 16 && mem_addr == 32'h1000, "R1 load", remain, 16);
    steps(20);
    chk(!busy && remain == 0 && irq && mem_addr == 32'h1010, "R4 natural end", mem_addr, 32'h1010);

    // R10 clear
    nxt_clr = 1; steps(2);
    chk(!irq, "R10 clear", irq, 0);

    // R5 restart with unchanged config
    nxt_en = 1; steps(2);
    chk(busy && mem_addr == 32'h1000 && remain == 16, "R5 restart", mem_addr, 32'h1000);
    // R11 enable while busy ignored
    cfg_start = 32'h8000; cfg_bytes = 64; nxt_en = 1; steps(2);
    chk(mem_addr != 32'h8000 && remain <= 16, "R11 enable while busy", remain, 16);
    steps(20);
    cfg_start = 32'h1000; cfg_bytes = 16;
    nxt_clr = 1; steps(2);
    // R11 stop while idle ignored
    nxt_stop = 1; steps(2);
    chk(!busy && !irq && remain == 0, "R11 stop while idle", irq, 0);

    // R6 auto reload
    ack_mode = 0; cfg_reload = 1; cfg_start = 32'h2000; cfg_bytes = 8; nxt_en = 1; steps(60);
    chk(busy && irq, "R6 reload keeps running", busy, 1);
    chk(mem_addr >= 32'h2000 && mem_addr <= 32'h2008, "R6 address window", mem_addr, 32'h2000);
    nxt_stop = 1; steps(3);
    chk(!busy, "R7 stop ends reload", busy, 0);
    cfg_reload = 0; ack_mode = 1; steps(4);
    nxt_clr = 1; steps(2);

    // R7 R8 R9 stop with write open
    cfg_start = 32'h3000; cfg_bytes = 32; nxt_en = 1; steps(4);
    chk(mem_req, "R3 request raised", mem_req, 1);
    nxt_stop = 1; steps(2);
    chk(stop_pending && !busy && irq && mem_req, "R8 pending", stop_pending, 1);
    nxt_en = 1; steps(3);
    chk(!busy && stop_pending, "R9 enable refused", busy, 0);
    ack_mode = 2; steps(3);
    chk(!stop_pending && !mem_req && remain == 28 && mem_addr == 32'h3004, "R7 residual", remain, 28);

    // R7 stop with no write open
    nxt_clr = 1; fv_mode = 0; ack_mode = 2; nxt_en = 1; steps(1);
    steps(3);
    nxt_stop = 1; steps(2);
    chk(!busy && !stop_pending && remain == 32 && irq, "R7 idle stop residual", remain, 32);
    fv_mode = 1;

    // R10 stop together with final ack
    nxt_clr = 1; ack_mode = 1; cfg_bytes = 4; steps(2);
    nxt_en = 1; steps(4);
    ack_mode = 2; nxt_stop = 1; steps(2);
    chk(!busy && !stop_pending && remain == 0 && irq, "R10 coincident end", remain, 0);
    nxt_clr = 1; steps(2);
    chk(!irq, "R10 single interrupt", irq, 0);
    steps(3);
    chk(!irq, "R10 stays clear", irq, 0);

    // random stress
    ack_mode = 0; fv_mode = 2;
    for (int i = 0; i < 4000; i++) begin
      cfg_start  = {$urandom % 65536, 2'b00};
      cfg_bytes  = 16'(4 * ($urandom % 7));
      cfg_reload = ($urandom % 4 == 0);
      nxt_en     = ($urandom % 8 == 0);
      nxt_stop   = ($urandom % 20 == 0);
      nxt_clr    = ($urandom % 6 == 0);
      step();
    end
    cfg_reload = 0; ack_mode = 2; steps(10);
    finish_run();
  end
endmodule